// File: doc/BRIEF.md
# Receive-Line Pulse Width Meter for Baud Detection

This block helps software find the bit rate of an incoming serial stream. It watches the raw receive line through a synchronizer and a glitch filter with a programmable width. While measurement is on, it records two things separately. The first is the narrowest low pulse between two accepted line edges, and the second is the narrowest high pulse. Both are counted in module clock cycles. The block also keeps a count of accepted edges.

Software turns measurement on, lets a few characters arrive, and then reads the two minima and the edge count. The narrowest pulse of either level is normally one bit time, and software derives the divisor from it. Turning measurement off returns all three results to their idle values, ready for the next attempt.

Top module: `autobaud_meas`

## Requirements
- R1: After reset both minimum outputs are all ones (0xFFFFF at the default 20-bit width) and the edge count is 0.
- R2: A level change on the receive line is accepted only after the synchronized line has shown the new level on more than F consecutive cycles, where F is the active filter width. A shorter excursion produces no edge and does not split the pulse it sits in.
- R3: While enabled, `low_min` holds the smallest low-pulse width seen, in clock cycles between the accepted falling and rising edges. The pulse that ends at the first accepted edge after enable is never measured.
- R4: While enabled, `high_min` holds the smallest high-pulse width seen, measured the same way. It is tracked independently of the low minimum.
- R5: While enabled, `edge_cnt` increases by one on every accepted edge of either direction and saturates at its all-ones value (1023 at the default 10-bit width).
- R6: The internal pulse-width count saturates at all ones. A pulse longer than that range compares as all ones and never wraps to a small value.
- R7: While the enable input is low, both minima read all ones and the edge count reads 0 from the next cycle on.
- R8: The filter width is captured from `filt_width` only while measurement is off. The captured register resets to 0x10. A change of `filt_width` during measurement has no effect until measurement is next turned off.
- R9: While enabled, a stored minimum never increases, and it changes only in a cycle where an edge is counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock; all widths are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_raw | input | 1 | Unsynchronized receive line, idle high |
| meas_en | input | 1 | Measurement enable; low clears results |
| filt_width | input | FILT_W (8) | Glitch filter width in cycles |
| low_min | output | WIDTH_W (20) | Narrowest low pulse seen |
| high_min | output | WIDTH_W (20) | Narrowest high pulse seen |
| edge_cnt | output | EDGE_W (10) | Number of accepted line edges, saturating |

## Verification
On every cycle, the assertions check that disabling clears the results and that the minima only ever fall. They also check that a minimum moves only together with a counted edge, that the two minima never change in the same cycle, and that the edge count steps by at most one. What they cannot see is whether the numbers are right. The exact widths, the filter boundary at F versus F+1 cycles, the rejection of a glitch inside a pulse, the capture rule for the filter width, and saturation without wrap-around are shown only by the bench's scenarios, which compare the outputs with widths the bench itself drove.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

   // Reset value of the captured glitch filter width
   localparam int unsigned AB_FILT_RESET = 16;

   // One accepted line transition, tagged with the level that just ended
   typedef struct packed {
      logic valid;
      logic ended_high;
   } ab_edge_t;

endpackage

// File: rtl/ab_sync.sv
module ab_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q <= '1;
            end else begin
               sh_q[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) begin
                  sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign q = sh_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ab_glitch_filter.sv
module ab_glitch_filter
   import autobaud_pkg::*;
#(
   parameter int unsigned FILT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_s,
   input  logic [FILT_W-1:0] thr,
   output ab_edge_t          ev
);

   logic              level_q;
   logic [FILT_W-1:0] run_q;
   logic              differs;
   logic              accept;

   assign differs = (rx_s != level_q);
   assign accept  = differs && (run_q >= thr);

   // run_q counts consecutive samples that disagree with the accepted level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b1;
         run_q   <= '0;
      end else if (!differs) begin
         run_q   <= '0;
      end else if (accept) begin
         level_q <= rx_s;
         run_q   <= '0;
      end else begin
         run_q   <= run_q + 1'b1;
      end
   end

   assign ev.valid      = accept;
   assign ev.ended_high = level_q;

endmodule

// File: rtl/ab_pulse_min.sv
module ab_pulse_min
   import autobaud_pkg::*;
#(
   parameter int unsigned WIDTH_W = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  ab_edge_t           ev,
   output logic [WIDTH_W-1:0] low_min,
   output logic [WIDTH_W-1:0] high_min
);

   localparam logic [WIDTH_W-1:0] W_MAX = '1;

   logic [WIDTH_W-1:0] wcnt_q;
   logic [WIDTH_W-1:0] lo_q;
   logic [WIDTH_W-1:0] hi_q;
   logic               primed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt_q   <= '0;
         primed_q <= 1'b0;
         lo_q     <= W_MAX;
         hi_q     <= W_MAX;
      end else if (clr) begin
         wcnt_q   <= '0;
         primed_q <= 1'b0;
         lo_q     <= W_MAX;
         hi_q     <= W_MAX;
      end else if (ev.valid) begin
         primed_q <= 1'b1;
         wcnt_q   <= {{(WIDTH_W-1){1'b0}}, 1'b1};
         if (primed_q) begin
            if (ev.ended_high) begin
               if (wcnt_q < hi_q) hi_q <= wcnt_q;
            end else begin
               if (wcnt_q < lo_q) lo_q <= wcnt_q;
            end
         end
      end else if (wcnt_q != W_MAX) begin
         wcnt_q <= wcnt_q + 1'b1;
      end
   end

   assign low_min  = lo_q;
   assign high_min = hi_q;

endmodule

// File: rtl/ab_edge_count.sv
module ab_edge_count
   import autobaud_pkg::*;
#(
   parameter int unsigned EDGE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  ab_edge_t          ev,
   output logic [EDGE_W-1:0] cnt
);

   localparam logic [EDGE_W-1:0] E_MAX = '1;

   logic [EDGE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (ev.valid && (cnt_q != E_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/autobaud_meas.sv
module autobaud_meas
   import autobaud_pkg::*;
#(
   parameter int unsigned FILT_W      = 8,
   parameter int unsigned WIDTH_W     = 20,
   parameter int unsigned EDGE_W      = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rxd_raw,
   input  logic               meas_en,
   input  logic [FILT_W-1:0]  filt_width,
   output logic [WIDTH_W-1:0] low_min,
   output logic [WIDTH_W-1:0] high_min,
   output logic [EDGE_W-1:0]  edge_cnt
);

   localparam logic [FILT_W-1:0] THR_RST = FILT_W'(AB_FILT_RESET);

   generate
      if (WIDTH_W < 2) begin : g_bad_width
         $error("autobaud_meas: WIDTH_W must be at least 2");
      end
      if (EDGE_W < 1) begin : g_bad_edge
         $error("autobaud_meas: EDGE_W must be at least 1");
      end
      if (FILT_W < 5) begin : g_bad_filt
         $error("autobaud_meas: FILT_W must hold the reset width");
      end
   endgenerate

   logic              rx_s;
   logic [FILT_W-1:0] thr_q;
   logic              clr;
   ab_edge_t          ev;

   assign clr = !meas_en;

   ab_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rxd_raw),
      .q     (rx_s)
   );

   // Filter width follows the input only while measurement is off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       thr_q <= THR_RST;
      else if (!meas_en) thr_q <= filt_width;
   end

   ab_glitch_filter #(.FILT_W(FILT_W)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .rx_s  (rx_s),
      .thr   (thr_q),
      .ev    (ev)
   );

   ab_pulse_min #(.WIDTH_W(WIDTH_W)) u_min (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .ev       (ev),
      .low_min  (low_min),
      .high_min (high_min)
   );

   ab_edge_count #(.EDGE_W(EDGE_W)) u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .ev    (ev),
      .cnt   (edge_cnt)
   );

endmodule

// File: rtl/ab_meas_chk.sv
module ab_meas_chk #(
   parameter int unsigned WIDTH_W = 20,
   parameter int unsigned EDGE_W  = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               meas_en,
   input logic [WIDTH_W-1:0] low_min,
   input logic [WIDTH_W-1:0] high_min,
   input logic [EDGE_W-1:0]  edge_cnt
);

   localparam logic [WIDTH_W-1:0] W_MAX = '1;
   localparam logic [EDGE_W-1:0]  E_MAX = '1;

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_en |=> (low_min == W_MAX && high_min == W_MAX && edge_cnt == '0));

   assert_low_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
      meas_en |=> (low_min <= $past(low_min)));

   assert_high_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
      meas_en |=> (high_min <= $past(high_min)));

   assert_edge_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      meas_en |=> (edge_cnt == $past(edge_cnt) || edge_cnt == $past(edge_cnt) + 1));

   assert_low_needs_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      meas_en |=> ($stable(low_min) || edge_cnt != $past(edge_cnt) || $past(edge_cnt) == E_MAX));

   assert_high_needs_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      meas_en |=> ($stable(high_min) || edge_cnt != $past(edge_cnt) || $past(edge_cnt) == E_MAX));

   // R3 / R4: one edge ends one pulse, so only one polarity can move per cycle
   assert_one_polarity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      meas_en |=> ($stable(low_min) || $stable(high_min)));

endmodule

bind autobaud_meas ab_meas_chk #(.WIDTH_W(WIDTH_W), .EDGE_W(EDGE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .meas_en  (meas_en),
   .low_min  (low_min),
   .high_min (high_min),
   .edge_cnt (edge_cnt)
);

// File: tb/tb_autobaud_meas.sv
module tb_autobaud_meas;

   localparam real CLK_NS = 8.0;

   typedef struct packed {
      int unsigned f;
      int unsigned la;
      int unsigned ha;
      int unsigned lb;
   } vec_t;

   // filter width, first low, high, second low (all wider than the filter)
   localparam vec_t VECS [6] = '{
      '{16, 40, 50,  30},
      '{ 0,  1,  1,   2},
      '{ 3,  4,  9,   7},
      '{10, 25, 11,  25},
      '{16, 17, 17, 100},
      '{ 1, 60,  2,   3}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        rxd;
   logic        en, en2;
   logic [7:0]  filt, filt2;
   logic [19:0] low_min, high_min;
   logic [9:0]  edge_cnt;
   logic [7:0]  low2, high2;
   logic [3:0]  edge2;

   int total = 0;
   int bad   = 0;

   always #(CLK_NS/2.0) clk = ~clk;

   autobaud_meas dut (
      .clk (clk), .rst_n (rst_n), .rxd_raw (rxd), .meas_en (en),
      .filt_width (filt), .low_min (low_min), .high_min (high_min),
      .edge_cnt (edge_cnt)
   );

   autobaud_meas #(.WIDTH_W(8), .EDGE_W(4)) dut_sat (
      .clk (clk), .rst_n (rst_n), .rxd_raw (rxd), .meas_en (en2),
      .filt_width (filt2), .low_min (low2), .high_min (high2),
      .edge_cnt (edge2)
   );

   task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Drive a level starting at a falling edge and keep it for n cycles
   task automatic hold(input logic lvl, input int n);
      rxd = lvl;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_NS * 190000.0);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rxd = 1'b1; en = 1'b1; en2 = 1'b0; filt = 8'd2; filt2 = 8'd0; rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle values straight out of reset
      chk("R1 low_min", low_min, 20'hFFFFF);
      chk("R1 high_min", high_min, 20'hFFFFF);
      chk("R1 edge_cnt", edge_cnt, 0);

      // R8: enabled since reset, so the reset width 16 applies, not 2
      hold(1, 20); hold(0, 10); hold(1, 30);
      chk("R8 reset width rejects 10", edge_cnt, 0);
      hold(0, 17); hold(1, 300);
      chk("R8 reset width accepts 17", edge_cnt, 2);

      // R2: glitch rejection, F = 8
      en = 1'b0; filt = 8'd8; hold(1, 3); en = 1'b1;
      hold(1, 20); hold(0, 8); hold(1, 30);
      chk("R2 glitch of F cycles", edge_cnt, 0);
      hold(0, 9); hold(1, 10); hold(0, 5); hold(1, 10); hold(0, 12); hold(1, 300);
      chk("R5 edges after glitch run", edge_cnt, 4);
      chk("R3 low_min F+1 boundary", low_min, 9);
      chk("R2 R4 glitch inside high", high_min, 25);

      // R8: width change during measurement is not taken
      filt = 8'd40;
      hold(0, 12); hold(1, 300);
      chk("R8 frozen width", edge_cnt, 6);

      // R7: disable clears everything
      en = 1'b0; hold(1, 2);
      chk("R7 low_min", low_min, 20'hFFFFF);
      chk("R7 high_min", high_min, 20'hFFFFF);
      chk("R7 edge_cnt", edge_cnt, 0);

      for (int i = 0; i < 6; i++) begin
         en = 1'b0; filt = 8'(VECS[i].f); hold(1, 3); en = 1'b1;
         hold(1, 20);
         hold(0, VECS[i].la);
         hold(1, VECS[i].ha);
         hold(0, VECS[i].lb);
         hold(1, 300);
         chk($sformatf("R3 vec%0d low_min", i), low_min,
             (VECS[i].la < VECS[i].lb) ? VECS[i].la : VECS[i].lb);
         chk($sformatf("R4 vec%0d high_min", i), high_min, VECS[i].ha);
         chk($sformatf("R5 vec%0d edge_cnt", i), edge_cnt, 4);
      end
      en = 1'b0; hold(1, 3);

      // R6 and saturation on the narrow instance (8-bit widths, 4-bit edges)
      en2 = 1'b1;
      hold(1, 20); hold(0, 300); hold(1, 5);
      chk("R6 long low does not wrap", low2, 255);
      hold(1, 5); hold(0, 5); hold(1, 10);
      chk("R4 narrow high_min", high2, 10);
      chk("R3 narrow low_min", low2, 5);
      for (int k = 0; k < 20; k++) begin
         hold(0, 3); hold(1, 3);
      end
      hold(1, 20);
      chk("R5 edge count saturates", edge2, 15);
      en2 = 1'b0; hold(1, 3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule